// File: doc/BRIEF.md
# Byte NVM Write Controller with Armed-Write Protection

This block connects a small CPU register port to an on-chip byte-wide non-volatile array. Software reaches three registers through a select code: an address register, a data register and a control register. A read strobe in the control register reads the array combinationally and loads the data register within the same access. A write is a two-step sequence. The first control write raises an arm flag, and a separate second control write carrying the write strobe must follow within a short window. Only then does programming begin.

Once a write launches, the block latches the data byte and holds the array's program line high. It times the programming interval with a counter that runs on a separate slow calibrated clock. The start and the completion cross between the two clock domains through toggle handshakes with two-flop synchronizers. A busy flag stays set for the whole interval, and a one-cycle done pulse marks its end. A stall output holds the CPU for a fixed number of cycles after each read or write launch.

Top module: `nvmByteCtrl`

## Requirements
- R1: The arming action is a control write (regSel = 2) with bit 2 = 1 and bit 1 = 0. It raises armOut on the next cycle. If no write launches, armOut falls by itself after exactly ARM_WIN (4) cycles. A write strobe sampled in any of those 4 cycles is accepted, and a strobe sampled later is ignored.
- R2: A control write with bit 1 = 1, sampled while armOut = 1, busyOut = 0 and flashBusy = 0, launches a write. On the next cycle busyOut = 1 and armOut = 0. A write strobe with armOut = 0 has no effect.
- R3: A control write with bit 2 and bit 1 both set, made while not armed, neither arms nor launches.
- R4: A write strobe sampled while flashBusy = 1 is rejected. busyOut stays 0.
- R5: busyOut stays high for at least PROG_CYCLES slow-clock periods. It then falls within the handshake latency (at most 4 further slow periods plus 4 CPU cycles). doneIrq is high for exactly the single cycle in which busyOut first reads 0.
- R6: While busyOut = 1, an address write (regSel = 0) leaves addrOut unchanged. A read strobe (bit 0) leaves dataOut and cpuStall unchanged.
- R7: A read strobe (control bit 0) sampled while idle loads dataOut with the array byte at addrOut on the next cycle. cpuStall is then high for exactly RD_STALL (4) cycles.
- R8: A write launch raises cpuStall for exactly WR_STALL (2) cycles.
- R9: During programming, memProg equals busyOut, memAddr equals addrOut, and memWdata holds the data register value captured at launch. Data register writes (regSel = 1) made during programming do not change memWdata.
- R10: Reset clears armOut, busyOut, cpuStall, doneIrq, addrOut and dataOut. A write cut off by reset never completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| slowClk | input | 1 | Calibrated slow clock that times programming |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 none |
| regWdata | input | BUS_W | Register write value; control bits: 0 read, 1 write, 2 arm |
| flashBusy | input | 1 | Busy flag from the flash self-programming engine |
| memRdata | input | DATA_W | Combinational array read data at memAddr |
| addrOut | output | ADDR_W | Address register |
| dataOut | output | DATA_W | Data register |
| armOut | output | 1 | Arm flag |
| busyOut | output | 1 | Write in progress |
| cpuStall | output | 1 | Holds the CPU |
| doneIrq | output | 1 | One-cycle programming-complete pulse |
| memAddr | output | ADDR_W | Array address |
| memWdata | output | DATA_W | Latched byte being programmed |
| memProg | output | 1 | Array program enable |

## Verification
Completion of programming and a new CPU access can fall on the same clock edge. In that cycle busy is still set, so a read strobe or a fresh armed write strobe must be rejected, and the same access made one cycle later must succeed. The bench provokes this by issuing read strobes on every cycle while a write is in flight, so one of them lands exactly on the completion edge. Its reference model keeps busy set through that edge and releases it only when the completion is observed. Every later cycle is then compared for data, stall and busy.

// File: rtl/nvmPkg.sv
package nvmPkg;
  // register select codes
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  // control register bit positions
  localparam int CTRL_RD  = 0;
  localparam int CTRL_WR  = 1;
  localparam int CTRL_ARM = 2;

  typedef struct packed {
    logic addrLd;
    logic dataLd;
    logic readLd;
    logic latchWr;
  } dpStrobeT;
endpackage

// File: rtl/nvmProgTimer.sv
module nvmProgTimer #(
  parameter int PROG_CYCLES = 8448,
  localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic slowClk,
  input  logic rstN,
  input  logic startTgl,
  output logic doneEv
);
  // slow domain: detect start toggle, count, toggle done
  logic [1:0]       startSync;
  logic             startSeen;
  logic             running;
  logic [CNT_W-1:0] cnt;
  logic             doneTgl;

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      startSync <= '0;
      startSeen <= 1'b0;
      running   <= 1'b0;
      cnt       <= '0;
      doneTgl   <= 1'b0;
    end else begin
      startSync <= {startSync[0], startTgl};
      if (startSync[1] != startSeen) begin
        startSeen <= startSync[1];
        running   <= 1'b1;
        cnt       <= CNT_W'(PROG_CYCLES - 1);
      end else if (running) begin
        if (cnt == '0) begin
          running <= 1'b0;
          doneTgl <= ~doneTgl;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // CPU domain: two-flop synchronizer and edge detect
  logic [1:0] doneSync;
  logic       doneSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneSync <= '0;
      doneSeen <= 1'b0;
    end else begin
      doneSync <= {doneSync[0], doneTgl};
      doneSeen <= doneSync[1];
    end
  end

  assign doneEv = doneSync[1] ^ doneSeen;
endmodule

// File: rtl/nvmCtrl.sv
module nvmCtrl import nvmPkg::*; #(
  parameter int ARM_WIN  = 4,
  parameter int WR_STALL = 2,
  parameter int RD_STALL = 4,
  localparam int ARM_W   = $clog2(ARM_WIN + 1),
  localparam int STALL_MAX = (WR_STALL > RD_STALL) ? WR_STALL : RD_STALL,
  localparam int STALL_W = $clog2(STALL_MAX + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [1:0] regSel,
  input  logic [2:0] ctrlBits,
  input  logic       flashBusy,
  input  logic       doneEv,
  output dpStrobeT   strobe,
  output logic       armQ,
  output logic       busyQ,
  output logic       startTgl,
  output logic       cpuStall,
  output logic       donePulse
);
  logic selCtrl, armReq, wrReq, rdReq, launch, readGo;
  logic [ARM_W-1:0]   armCnt;
  logic [STALL_W-1:0] stallCnt;

  assign selCtrl = regWe && (regSel == SEL_CTRL);
  assign armReq  = selCtrl && ctrlBits[CTRL_ARM] && !ctrlBits[CTRL_WR];
  assign wrReq   = selCtrl && ctrlBits[CTRL_WR];
  assign rdReq   = selCtrl && ctrlBits[CTRL_RD];
  assign launch  = wrReq && armQ && !busyQ && !flashBusy;
  assign readGo  = rdReq && !busyQ && !launch;

  always_comb begin
    strobe.addrLd  = regWe && (regSel == SEL_ADDR) && !busyQ;
    strobe.dataLd  = regWe && (regSel == SEL_DATA);
    strobe.readLd  = readGo;
    strobe.latchWr = launch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armQ      <= 1'b0;
      armCnt    <= '0;
      busyQ     <= 1'b0;
      startTgl  <= 1'b0;
      stallCnt  <= '0;
      donePulse <= 1'b0;
    end else begin
      if (launch) begin
        armQ <= 1'b0;
      end else if (armReq) begin
        armQ   <= 1'b1;
        armCnt <= ARM_W'(ARM_WIN - 1);
      end else if (armQ) begin
        if (armCnt == '0) armQ <= 1'b0;
        else              armCnt <= armCnt - 1'b1;
      end

      if (launch) begin
        busyQ    <= 1'b1;
        startTgl <= ~startTgl;
      end else if (doneEv) begin
        busyQ <= 1'b0;
      end
      donePulse <= doneEv && busyQ;

      if (launch)               stallCnt <= STALL_W'(WR_STALL);
      else if (readGo)          stallCnt <= STALL_W'(RD_STALL);
      else if (stallCnt != '0)  stallCnt <= stallCnt - 1'b1;
    end
  end

  assign cpuStall = (stallCnt != '0);

  // R5
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!busyQ && $past(busyQ)));
  // R4
  flash_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> !$past(flashBusy));
  // R2
  launch_disarms_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> !armQ);
  // R8
  stall_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuStall) |=> cpuStall);
endmodule

// File: rtl/nvmDatapath.sv
module nvmDatapath import nvmPkg::*; #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int BUS_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic              busy,
  input  logic [BUS_W-1:0]  regWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] dataQ,
  output logic [DATA_W-1:0] wrLatchQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      dataQ    <= '0;
      wrLatchQ <= '0;
    end else begin
      if (strobe.addrLd) addrQ <= regWdata[ADDR_W-1:0];
      if (strobe.readLd)      dataQ <= memRdata;
      else if (strobe.dataLd) dataQ <= regWdata[DATA_W-1:0];
      if (strobe.latchWr) wrLatchQ <= dataQ;
    end
  end

  // R6
  addr_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(addrQ));
  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(wrLatchQ));
endmodule

// File: rtl/nvmByteCtrl.sv
module nvmByteCtrl import nvmPkg::*; #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int ARM_WIN     = 4,
  parameter int PROG_CYCLES = 8448,
  parameter int WR_STALL    = 2,
  parameter int RD_STALL    = 4,
  localparam int BUS_W      = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowClk,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [BUS_W-1:0]  regWdata,
  input  logic              flashBusy,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              armOut,
  output logic              busyOut,
  output logic              cpuStall,
  output logic              doneIrq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memProg
);
  dpStrobeT strobe;
  logic     startTgl, doneEv;

  nvmCtrl #(.ARM_WIN(ARM_WIN), .WR_STALL(WR_STALL), .RD_STALL(RD_STALL)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .ctrlBits(regWdata[2:0]), .flashBusy(flashBusy), .doneEv(doneEv),
    .strobe(strobe), .armQ(armOut), .busyQ(busyOut), .startTgl(startTgl),
    .cpuStall(cpuStall), .donePulse(doneIrq));

  nvmDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busyOut),
    .regWdata(regWdata), .memRdata(memRdata),
    .addrQ(addrOut), .dataQ(dataOut), .wrLatchQ(memWdata));

  nvmProgTimer #(.PROG_CYCLES(PROG_CYCLES)) uTimer (
    .clk(clk), .slowClk(slowClk), .rstN(rstN),
    .startTgl(startTgl), .doneEv(doneEv));

  assign memAddr = addrOut;
  assign memProg = busyOut;
endmodule

// File: tb/sim_nvmByteCtrl.sv
module sim_nvmByteCtrl;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int PROG   = 10;
  localparam int RATIO  = 4;             // slow period in CPU cycles
  localparam int MIN_E  = PROG * RATIO;
  localparam int MAX_E  = (PROG + 4) * RATIO + 4;
  localparam int BUS_W  = 8;

  logic clk = 0, slowClk = 0, rstN = 0;
  logic regWe = 0, flashBusy = 0;
  logic [1:0] regSel = 0;
  logic [BUS_W-1:0] regWdata = 0;
  logic [DATA_W-1:0] memRdata;
  logic [ADDR_W-1:0] addrOut, memAddr;
  logic [DATA_W-1:0] dataOut, memWdata;
  logic armOut, busyOut, cpuStall, doneIrq, memProg;
  logic [7:0] arr [64];

  always #4 clk = ~clk;
  always #16 slowClk = ~slowClk;

  assign memRdata = arr[memAddr];

  nvmByteCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rstN(rstN), .slowClk(slowClk), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .flashBusy(flashBusy), .memRdata(memRdata),
    .addrOut(addrOut), .dataOut(dataOut), .armOut(armOut), .busyOut(busyOut),
    .cpuStall(cpuStall), .doneIrq(doneIrq), .memAddr(memAddr),
    .memWdata(memWdata), .memProg(memProg));

  int nChecks = 0, nFails = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model state
  int mArm = 0, mStall = 0, mElapsed = 0;
  bit mBusy = 0;
  int mAddr = 0, mData = 0, mLatch = 0;

  always begin
    @(posedge clk);
    cycles++;
    if (!rstN) begin
      mArm = 0; mStall = 0; mBusy = 0; mElapsed = 0;
      mAddr = 0; mData = 0; mLatch = 0;
    end else begin : step
      bit ctl, launch, readGo;
      ctl    = regWe && regSel == 2;
      launch = ctl && regWdata[1] && mArm > 0 && !mBusy && !flashBusy;
      readGo = ctl && regWdata[0] && !mBusy && !launch;
      if (launch) mArm = 0;
      else if (ctl && regWdata[2] && !regWdata[1]) mArm = 4;
      else if (mArm > 0) mArm--;
      if (launch) mStall = 2;
      else if (readGo) mStall = 4;
      else if (mStall > 0) mStall--;
      if (launch) begin mLatch = mData; mBusy = 1; mElapsed = 0; end
      else if (mBusy) mElapsed++;
      if (readGo) mData = arr[mAddr];
      else if (regWe && regSel == 1) mData = regWdata;
      if (regWe && regSel == 0 && !mBusy) mAddr = regWdata[ADDR_W-1:0];
    end
    #2;
    if (rstN) begin
      chk(armOut == (mArm > 0), "R1", "armOut", armOut, mArm > 0);
      chk(cpuStall == (mStall > 0), "R8", "cpuStall", cpuStall, mStall > 0);
      chk(addrOut == mAddr, "R6", "addrOut", addrOut, mAddr);
      chk(dataOut == mData, "R7", "dataOut", dataOut, mData);
      chk(memProg == busyOut && memAddr == addrOut, "R9", "memProg/memAddr",
          memProg, busyOut);
      if (mBusy) begin
        if (!busyOut) begin
          chk(mElapsed >= MIN_E && mElapsed <= MAX_E, "R5", "busy length",
              mElapsed, MIN_E);
          chk(doneIrq == 1, "R5", "doneIrq at completion", doneIrq, 1);
          arr[mAddr] = mLatch[7:0];
          mBusy = 0;
        end else begin
          chk(mElapsed <= MAX_E, "R5", "busy overrun", mElapsed, MAX_E);
          chk(doneIrq == 0, "R5", "doneIrq while busy", doneIrq, 0);
          chk(memWdata == mLatch, "R9", "memWdata", memWdata, mLatch);
        end
      end else begin
        chk(busyOut == 0, "R2", "busyOut idle", busyOut, 0);
        chk(doneIrq == 0, "R5", "doneIrq idle", doneIrq, 0);
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] val);
    regWe = 1; regSel = sel; regWdata = val;
    @(negedge clk);
    regWe = 0; regSel = 0; regWdata = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitIdle(input bit readSpam);
    for (int i = 0; i < 200 && (mBusy || busyOut); i++) begin
      if (readSpam) wr(2, 8'h01); else @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) arr[i] = 8'(i * 7 + 3);
    idle(3);
    rstN = 1;
    idle(1);
    // R10 reset state
    chk(!armOut && !busyOut && !cpuStall && !doneIrq && addrOut == 0 && dataOut == 0,
        "R10", "reset state", busyOut, 0);

    // R7 read
    wr(0, 8'd5);
    wr(2, 8'h01);
    chk(dataOut == 8'd38 && cpuStall, "R7", "read data", dataOut, 38);
    idle(5);

    // R2 strobe without arm ignored
    wr(1, 8'hA5);
    wr(2, 8'h02);
    chk(busyOut == 0, "R2", "unarmed strobe", busyOut, 0);

    // R2 R8 R9 launch at last window cycle (R1 boundary), then lockout
    wr(2, 8'h04);
    idle(3);
    wr(2, 8'h02);
    chk(busyOut == 1 && cpuStall == 1 && armOut == 0, "R2", "launch", busyOut, 1);
    wr(0, 8'd9);            // R6 ignored
    wr(1, 8'h3C);           // R9 latch unaffected
    chk(memWdata == 8'hA5, "R9", "latched byte", memWdata, 8'hA5);
    waitIdle(1);            // read strobes collide with completion
    idle(6);
    wr(2, 8'h01);
    chk(dataOut == 8'hA5, "R5", "byte programmed", dataOut, 8'hA5);
    idle(5);

    // R1 expired window
    wr(2, 8'h04);
    idle(4);
    wr(2, 8'h02);
    chk(busyOut == 0 && armOut == 0, "R1", "late strobe", busyOut, 0);

    // R3 arm and strobe together
    wr(2, 8'h06);
    chk(busyOut == 0 && armOut == 0, "R3", "combined write", armOut, 0);
    idle(1);

    // R4 flash busy
    flashBusy = 1;
    wr(2, 8'h04);
    wr(2, 8'h02);
    chk(busyOut == 0, "R4", "flash busy reject", busyOut, 0);
    flashBusy = 0;
    idle(5);

    // R10 reset mid-write
    wr(0, 8'd12);
    wr(1, 8'h77);
    wr(2, 8'h04);
    wr(2, 8'h02);
    idle(8);
    rstN = 0;
    idle(2);
    rstN = 1;
    idle(MAX_E + 4);
    chk(busyOut == 0 && doneIrq == 0, "R10", "aborted write", busyOut, 0);
    wr(0, 8'd12);
    wr(2, 8'h01);
    chk(dataOut == 8'd87, "R10", "cell untouched", dataOut, 87);
    idle(6);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule